// File: doc/BRIEF.md
# Graphics DRAM Burst Timing Sequencer

This block reproduces the data-phase timing of a graphics DRAM device. It accepts READ and WRITE commands that have already been registered, each with a column address. For every command it produces a strobe that marks the beats of the burst and, on each beat, the column being transferred. Read strobes start a CAS latency after the command. Write-capture strobes start a write latency after the command. The block also drives the enable of the data and mask input receivers. For short write latencies the enable stays on. For long write latencies it is opened by each write and closed again once that write's burst has been captured.

The configuration pins are static between bursts:
- a burst-length select (4 or 8 beats);
- an interleave request, which is always refused;
- a speed-range select, which sets the legal CAS latency window;
- the CAS latency;
- the write latency.

An illegal setting raises `cfg_err`, and commands are discarded while it is high.

The latency of each command is held in a delay line, one for reads and one for writes. Each line feeds a two-state beat engine:
- **BE_IDLE**: moves to BE_BURST when a delayed start appears.
- **BE_BURST**: stays in BE_BURST for each further beat. A new start restarts the count at beat 0, which allows gapless bursts. After the last beat it returns to BE_IDLE.

The receiver gate has three states:
- **RX_ALWAYS**: the enable is on. It goes to RX_OFF when the write latency becomes 5 or more, or to RX_ON if a write arrives at that same time.
- **RX_OFF**: it goes to RX_ON on an accepted write, or to RX_ALWAYS when the write latency drops to 4 or less.
- **RX_ON**: a window counter runs. It goes back to RX_OFF when the counter expires. A new write reloads the counter. It goes to RX_ALWAYS when the write latency drops to 4 or less.

Top module: `gbs_seq`

## Requirements
- R1: `cfg_bl8`=0 selects 4-beat bursts and `cfg_bl8`=1 selects 8-beat bursts. `rd_valid` and `wr_capture` are each high for exactly that many consecutive cycles per command.
- R2: Column bits 1 and 0 of a command are ignored and treated as zero. The first beat of every burst reports column bits [1:0] = 0, and column bits above bit 2 are passed through unchanged.
- R3: In a 4-beat burst, column bits [1:0] take the values 0,1,2,3 on successive beats, and bit 2 keeps its commanded value.
- R4: In an 8-beat burst, column bits [2:0] run 0..7 when commanded bit 2 is 0, and 4,5,6,7,0,1,2,3 when it is 1.
- R5: A READ sampled at clock edge n with CAS latency m raises `rd_valid` at edge n+m.
- R6: With `cfg_hs`=0 the legal CAS latency is 7 to 14. With `cfg_hs`=1 it is 10 to 17. Any other value raises `cfg_err`.
- R7: A WRITE sampled at edge n with write latency WL raises `wr_capture` at edge n+WL, and `wr_col` follows the same column order as reads.
- R8: While the write latency is 3 or 4, `rcv_en` is high in every cycle.
- R9: While the write latency is 5, 6 or 7, `rcv_en` is low when no write is pending. It rises at the edge that samples a WRITE and falls WL+BL edges after it.
- R10: A WRITE sampled while an earlier write window is still open restarts the window. `rcv_en` then stays high until WL+BL edges after the later WRITE, and both bursts are captured back to back.
- R11: `cfg_err` is high when an interleaved order is requested or the write latency is outside 3 to 7. While it is high, READ and WRITE commands produce no strobe and do not open the receiver window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all edges counted in the requirements are rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rd | input | 1 | Registered READ command strobe |
| cmd_wr | input | 1 | Registered WRITE command strobe |
| cmd_col | input | COL_W | Column address of the command |
| cfg_bl8 | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| cfg_interleave | input | 1 | Request for interleaved order (always refused) |
| cfg_hs | input | 1 | CAS latency range select: 0 = 7..14, 1 = 10..17 |
| cfg_cl | input | CL_W | CAS latency in cycles |
| cfg_wl | input | WL_W | Write latency in cycles |
| cfg_err | output | 1 | Illegal configuration; commands are dropped |
| rcv_en | output | 1 | Data and mask input receiver enable |
| rd_valid | output | 1 | Read data beat is driven |
| rd_col | output | COL_W | Column of the current read beat |
| wr_capture | output | 1 | Write data beat is captured |
| wr_col | output | COL_W | Column of the current write beat |

## Verification
Reads are swept over every legal CAS latency in both speed ranges, both burst lengths, and columns that differ in bit 2 and carry nonzero low bits. This separates latency errors from ordering errors, and shows whether the low bits are really discarded. Writes are swept over every legal write latency and both burst lengths. This exposes the boundary between always-on and gated receivers at WL 4/5, and the WL+BL closing point. A pair of writes spaced one burst apart checks that the window is reloaded rather than closed early. Out-of-range latencies on both sides of each window, and an interleave request, are each followed by commands to confirm that they are dropped.

// File: rtl/gbs_pkg.sv
package gbs_pkg;
    localparam int CL_MID_MIN   = 7;
    localparam int CL_MID_MAX   = 14;
    localparam int CL_HS_MIN    = 10;
    localparam int CL_HS_MAX    = 17;
    localparam int WL_MIN       = 3;
    localparam int WL_MAX       = 7;
    localparam int WL_GATED_MIN = 5;
    localparam int BEATS_MAX    = 8;

    typedef enum logic {
        BE_IDLE,
        BE_BURST
    } beat_state_e;

    typedef enum logic [1:0] {
        RX_OFF,
        RX_ON,
        RX_ALWAYS
    } rx_state_e;
endpackage

// File: rtl/gbs_lat_line.sv
module gbs_lat_line #(
    parameter int DEPTH = 17,
    parameter int PW    = 11,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LAT_W-1:0] lat,
    input  logic [PW-1:0]    payload,
    output logic             pop,
    output logic [PW-1:0]    pop_payload
);
    logic [DEPTH-1:0] vld_q, vld_d;
    logic [PW-1:0]    pay_q [DEPTH];
    logic [PW-1:0]    pay_d [DEPTH];

    // A command with latency L lands in slot L-1 and pops L-1 edges later.
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic          hit;
        logic          up_v;
        logic [PW-1:0] up_p;
        if (k == DEPTH - 1) begin : g_top
            assign up_v = 1'b0;
            assign up_p = '0;
        end else begin : g_mid
            assign up_v = vld_q[k+1];
            assign up_p = pay_q[k+1];
        end
        assign hit      = push && (lat == LAT_W'(k + 1));
        assign vld_d[k] = hit | up_v;
        assign pay_d[k] = hit ? payload : up_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) pay_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < DEPTH; i++) pay_q[i] <= pay_d[i];
        end
    end

    assign pop         = vld_q[0];
    assign pop_payload = pay_q[0];
endmodule

// File: rtl/gbs_beat_gen.sv
module gbs_beat_gen
    import gbs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bl8,
    input  logic [COL_W-1:0] start_col,
    output logic             valid,
    output logic [COL_W-1:0] col
);
    localparam int BEAT_W = $clog2(BEATS_MAX);

    beat_state_e       st_q, st_d;
    logic [BEAT_W-1:0] beat_q, beat_d, last_beat;
    logic [COL_W-1:0]  base_q, sel_base, col_d;
    logic              bl8_q, sel_bl8;

    assign last_beat = bl8_q ? BEAT_W'(7) : BEAT_W'(3);

    always_comb begin
        st_d   = st_q;
        beat_d = beat_q;
        unique case (st_q)
            BE_IDLE: begin
                if (start) begin
                    st_d   = BE_BURST;
                    beat_d = '0;
                end
            end
            BE_BURST: begin
                if (start) begin
                    beat_d = '0;
                end else if (beat_q == last_beat) begin
                    st_d = BE_IDLE;
                end else begin
                    beat_d = beat_q + BEAT_W'(1);
                end
            end
            default: st_d = BE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BE_IDLE;
            beat_q <= '0;
            base_q <= '0;
            bl8_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            beat_q <= beat_d;
            if (start) begin
                base_q <= start_col;
                bl8_q  <= start_bl8;
            end
        end
    end

    // Sequential order only: 8-beat bursts wrap within the aligned 8-group.
    always_comb begin
        sel_base = start ? start_col : base_q;
        sel_bl8  = start ? start_bl8 : bl8_q;
        col_d    = sel_base;
        if (sel_bl8) col_d[2:0] = {sel_base[2], 2'b00} + beat_d;
        else         col_d[1:0] = beat_d[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            col   <= '0;
        end else begin
            valid <= (st_d == BE_BURST);
            col   <= (st_d == BE_BURST) ? col_d : '0;
        end
    end
endmodule

// File: rtl/gbs_rx_gate.sv
module gbs_rx_gate
    import gbs_pkg::*;
#(
    parameter int WL_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_go,
    input  logic            cfg_bl8,
    input  logic [WL_W-1:0] cfg_wl,
    output logic            rcv_en
);
    rx_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, win;
    logic             gated;

    assign gated = int'(cfg_wl) >= WL_GATED_MIN;
    assign win   = CNT_W'(cfg_wl) + (cfg_bl8 ? CNT_W'(8) : CNT_W'(4)) - CNT_W'(1);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RX_ALWAYS: begin
                if (gated) begin
                    st_d = wr_go ? RX_ON : RX_OFF;
                    if (wr_go) cnt_d = win;
                end
            end
            RX_OFF: begin
                if (!gated) begin
                    st_d = RX_ALWAYS;
                end else if (wr_go) begin
                    st_d  = RX_ON;
                    cnt_d = win;
                end
            end
            RX_ON: begin
                if (!gated)               st_d  = RX_ALWAYS;
                else if (wr_go)           cnt_d = win;
                else if (cnt_q == '0)     st_d  = RX_OFF;
                else                      cnt_d = cnt_q - CNT_W'(1);
            end
            default: st_d = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign rcv_en = (st_q != RX_OFF);
endmodule

// File: rtl/gbs_seq.sv
module gbs_seq
    import gbs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int CL_W  = 5,
    parameter int WL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cfg_bl8,
    input  logic             cfg_interleave,
    input  logic             cfg_hs,
    input  logic [CL_W-1:0]  cfg_cl,
    input  logic [WL_W-1:0]  cfg_wl,
    output logic             cfg_err,
    output logic             rcv_en,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col,
    output logic             wr_capture,
    output logic [COL_W-1:0] wr_col
);
    localparam int RD_DEPTH = CL_HS_MAX;
    localparam int WR_DEPTH = WL_MAX;
    localparam int PAY_W    = COL_W + 1;
    localparam int CNT_W    = $clog2(WL_MAX + BEATS_MAX + 1);

    int               cl_lo, cl_hi;
    logic             cl_bad, wl_bad, rd_go, wr_go;
    logic [PAY_W-1:0] cmd_pay, rd_pay, wr_pay;
    logic             rd_start, wr_start;

    always_comb begin
        cl_lo  = cfg_hs ? CL_HS_MIN : CL_MID_MIN;
        cl_hi  = cfg_hs ? CL_HS_MAX : CL_MID_MAX;
        cl_bad = (int'(cfg_cl) < cl_lo) || (int'(cfg_cl) > cl_hi);
        wl_bad = (int'(cfg_wl) < WL_MIN) || (int'(cfg_wl) > WL_MAX);
    end

    assign cfg_err = cfg_interleave | cl_bad | wl_bad;
    assign rd_go   = cmd_rd & ~cfg_err;
    assign wr_go   = cmd_wr & ~cfg_err;
    assign cmd_pay = {cfg_bl8, cmd_col & ~COL_W'(3)};

    gbs_lat_line #(.DEPTH(RD_DEPTH), .PW(PAY_W), .LAT_W(CL_W)) i_rd_line (
        .clk(clk), .rst_n(rst_n), .push(rd_go), .lat(cfg_cl),
        .payload(cmd_pay), .pop(rd_start), .pop_payload(rd_pay)
    );

    gbs_lat_line #(.DEPTH(WR_DEPTH), .PW(PAY_W), .LAT_W(WL_W)) i_wr_line (
        .clk(clk), .rst_n(rst_n), .push(wr_go), .lat(cfg_wl),
        .payload(cmd_pay), .pop(wr_start), .pop_payload(wr_pay)
    );

    gbs_beat_gen #(.COL_W(COL_W)) i_rd_beats (
        .clk(clk), .rst_n(rst_n), .start(rd_start),
        .start_bl8(rd_pay[COL_W]), .start_col(rd_pay[COL_W-1:0]),
        .valid(rd_valid), .col(rd_col)
    );

    gbs_beat_gen #(.COL_W(COL_W)) i_wr_beats (
        .clk(clk), .rst_n(rst_n), .start(wr_start),
        .start_bl8(wr_pay[COL_W]), .start_col(wr_pay[COL_W-1:0]),
        .valid(wr_capture), .col(wr_col)
    );

    gbs_rx_gate #(.WL_W(WL_W), .CNT_W(CNT_W)) i_rx_gate (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .cfg_bl8(cfg_bl8),
        .cfg_wl(cfg_wl), .rcv_en(rcv_en)
    );
endmodule

// File: rtl/gbs_seq_chk.sv
module gbs_seq_chk #(
    parameter int COL_W = 10,
    parameter int WL_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic             cfg_err,
    input logic [WL_W-1:0]  cfg_wl,
    input logic             rcv_en,
    input logic             rd_valid,
    input logic [COL_W-1:0] rd_col,
    input logic             wr_capture,
    input logic [COL_W-1:0] wr_col
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_RX_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(cfg_wl) >= WL_W'(3) && $past(cfg_wl) <= WL_W'(4)) |-> rcv_en); // R8

    AST_RX_RISE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(rcv_en) && $past(cfg_wl) >= WL_W'(5)) |-> $past(cmd_wr && !cfg_err)); // R11

    AST_CAPTURE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_capture |-> rcv_en); // R9

    AST_RD_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (rd_col[1:0] == 2'b00)); // R2

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_col[1:0] == $past(rd_col[1:0]) + 2'd1)); // R3

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_capture && $past(wr_capture)) |-> (wr_col[1:0] == $past(wr_col[1:0]) + 2'd1)); // R7
endmodule

bind gbs_seq gbs_seq_chk #(.COL_W(COL_W), .WL_W(WL_W)) i_gbs_seq_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cfg_err(cfg_err), .cfg_wl(cfg_wl),
    .rcv_en(rcv_en), .rd_valid(rd_valid), .rd_col(rd_col),
    .wr_capture(wr_capture), .wr_col(wr_col)
);

// File: tb/test_gbs_seq.sv
module test_gbs_seq;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_rd = 1'b0, cmd_wr = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cfg_bl8 = 1'b0, cfg_interleave = 1'b0, cfg_hs = 1'b0;
    logic [4:0]       cfg_cl = 5'd7;
    logic [2:0]       cfg_wl = 3'd3;
    logic             cfg_err, rcv_en, rd_valid, wr_capture;
    logic [COL_W-1:0] rd_col, wr_col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gbs_seq i_gbs_seq (
        .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_col(cmd_col),
        .cfg_bl8(cfg_bl8), .cfg_interleave(cfg_interleave), .cfg_hs(cfg_hs),
        .cfg_cl(cfg_cl), .cfg_wl(cfg_wl), .cfg_err(cfg_err), .rcv_en(rcv_en),
        .rd_valid(rd_valid), .rd_col(rd_col), .wr_capture(wr_capture), .wr_col(wr_col)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c, input bit bl8, input int beat);
        logic [COL_W-1:0] r;
        r = c;
        if (bl8) r[2:0] = 3'((int'(c[2]) * 4 + beat) % 8);
        else     r[1:0] = 2'(beat % 4);
        return r;
    endfunction

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // R1 R2 R3 R4 R5: one read, every cycle checked against the expected strobe and column
    task automatic run_read(input logic [COL_W-1:0] c);
        int cl, bl;
        cl = int'(cfg_cl);
        bl = cfg_bl8 ? 8 : 4;
        settle();
        cmd_rd = 1'b1; cmd_col = c;
        @(negedge clk);
        cmd_rd = 1'b0;
        for (int k = 0; k <= cl + bl + 1; k++) begin
            bit ev;
            ev = (k >= cl) && (k < cl + bl);
            check(rd_valid == ev, "R5", int'(rd_valid), int'(ev));
            if (ev) check(rd_col == exp_col(c, cfg_bl8, k - cl),
                          cfg_bl8 ? "R4" : "R3", int'(rd_col), int'(exp_col(c, cfg_bl8, k - cl)));
            @(negedge clk);
        end
    endtask

    // R7 R8 R9: one write with receiver window checked
    task automatic run_write(input logic [COL_W-1:0] c);
        int wl, bl;
        wl = int'(cfg_wl);
        bl = cfg_bl8 ? 8 : 4;
        settle();
        check(rcv_en == (wl <= 4), wl <= 4 ? "R8" : "R9", int'(rcv_en), int'(wl <= 4));
        cmd_wr = 1'b1; cmd_col = c;
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int k = 0; k <= wl + bl + 1; k++) begin
            bit ev, er;
            ev = (k >= wl) && (k < wl + bl);
            er = (wl <= 4) || (k < wl + bl);
            check(wr_capture == ev, "R7", int'(wr_capture), int'(ev));
            check(rcv_en == er, wl <= 4 ? "R8" : "R9", int'(rcv_en), int'(er));
            if (ev) check(wr_col == exp_col(c, cfg_bl8, k - wl), "R7",
                          int'(wr_col), int'(exp_col(c, cfg_bl8, k - wl)));
            @(negedge clk);
        end
    endtask

    // R11: a command under an illegal configuration must leave every strobe low
    task automatic run_dropped(input bit is_rd);
        int hits;
        hits = 0;
        settle();
        check(cfg_err == 1'b1, "R11", int'(cfg_err), 1);
        if (is_rd) cmd_rd = 1'b1; else cmd_wr = 1'b1;
        cmd_col = 10'h2A7;
        @(negedge clk);
        cmd_rd = 1'b0; cmd_wr = 1'b0;
        for (int k = 0; k < 26; k++) begin
            if (rd_valid || wr_capture) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R11", hits, 0);
    endtask

    initial begin
        logic [COL_W-1:0] cols [3];
        cols[0] = 10'h2A7; cols[1] = 10'h153; cols[2] = 10'h004;

        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0 && wr_capture == 1'b0, "R1", int'(rd_valid | wr_capture), 0);
        rst_n = 1'b1;
        settle();
        check(rcv_en == 1'b1, "R8", int'(rcv_en), 1);

        // Read sweep: both ranges, all legal latencies, both lengths (R1 R4 R5 R6)
        for (int hs = 0; hs < 2; hs++) begin
            for (int cl = (hs ? 10 : 7); cl <= (hs ? 17 : 14); cl++) begin
                cfg_hs = 1'(hs); cfg_cl = 5'(cl);
                @(negedge clk);
                check(cfg_err == 1'b0, "R6", int'(cfg_err), 0);
                for (int b = 0; b < 2; b++) begin
                    cfg_bl8 = 1'(b);
                    for (int i = 0; i < 3; i++) run_read(cols[i]);
                end
            end
        end

        // Write sweep: every legal write latency, both lengths (R7 R8 R9)
        cfg_hs = 1'b0; cfg_cl = 5'd7;
        for (int wl = 3; wl <= 7; wl++) begin
            cfg_wl = 3'(wl);
            for (int b = 0; b < 2; b++) begin
                cfg_bl8 = 1'(b);
                for (int i = 0; i < 3; i++) run_write(cols[i]);
            end
        end

        // R10: second write one burst after the first reloads the window
        cfg_wl = 3'd6; cfg_bl8 = 1'b0;
        settle();
        cmd_wr = 1'b1; cmd_col = 10'h0A1;
        @(negedge clk);
        for (int k = 0; k <= 16; k++) begin
            bit ev, er;
            logic [COL_W-1:0] ec;
            cmd_wr = 1'b0;
            er = (k < 14);
            ev = (k >= 6) && (k <= 13);
            ec = (k < 10) ? exp_col(10'h0A1, 1'b0, k - 6) : exp_col(10'h1F6, 1'b0, k - 10);
            check(rcv_en == er, "R10", int'(rcv_en), int'(er));
            check(wr_capture == ev, "R10", int'(wr_capture), int'(ev));
            if (ev) check(wr_col == ec, "R10", int'(wr_col), int'(ec));
            if (k == 3) begin cmd_wr = 1'b1; cmd_col = 10'h1F6; end
            @(negedge clk);
        end

        // R6 R11: out-of-range CAS latencies on both sides of each window
        cfg_wl = 3'd3;
        cfg_hs = 1'b0; cfg_cl = 5'd6;  run_dropped(1'b1);
        cfg_hs = 1'b0; cfg_cl = 5'd15; run_dropped(1'b1);
        cfg_hs = 1'b1; cfg_cl = 5'd9;  run_dropped(1'b1);
        cfg_hs = 1'b1; cfg_cl = 5'd18; run_dropped(1'b1);
        cfg_hs = 1'b0; cfg_cl = 5'd7;
        cfg_wl = 3'd2; run_dropped(1'b0);
        cfg_wl = 3'd0; run_dropped(1'b0);

        // R11: interleave request refused; gated receiver must stay closed
        cfg_wl = 3'd6; cfg_interleave = 1'b1;
        settle();
        check(rcv_en == 1'b0, "R11", int'(rcv_en), 0);
        cmd_wr = 1'b1; cmd_col = 10'h010;
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int k = 0; k < 16; k++) begin
            check(rcv_en == 1'b0 && wr_capture == 1'b0, "R11", int'(rcv_en | wr_capture), 0);
            @(negedge clk);
        end
        cfg_interleave = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule